// File: doc/BRIEF.md
# Completion Event Ring Writer

This block is the producer end of a circular completion-event ring held in system memory. A transfer engine hands it one completion at a time, carrying a 4-bit completion code (1 for success, 4 for error) and a 4-bit error-information nibble. For each one the block formats a 16-byte event record and issues a single-beat memory write at the ring base plus the current write offset. Only after the memory side acknowledges that write does it advance its write offset and pulse an end-of-block event toward the interrupt unit. The record is therefore always in memory before software can see it.

Software programs a 64-bit ring base and a ring length in bytes. It polls the write offset, and it returns consumed space by writing its read offset to a doorbell. Offsets are byte offsets in steps of 16. The block holds off the completion handshake whenever one more record would make the write offset catch up with the read offset, so a full ring is never overrun.

Top module: `ering_writer`

## Requirements
- R1: Register map, byte offsets on `reg_addr`: 0x008 is the base low word, 0x00C the base high word, 0x010 the ring length in bytes, 0x020 the write offset (read only) and 0x400 the doorbell (write only, reads as zero). After reset every register reads zero, `mem_req` and `eob_pulse` are low, and `cmp_ready` is low while the ring length is zero.
- R2: Each record is one 128-bit write to address base + write offset. Bits [31:28] of `mem_wdata` hold the completion code, bits [27:24] hold the error information, and every other bit is zero. Code values such as 1 (success) and 4 (error) pass through unchanged.
- R3: After each acknowledged record the write offset grows by 16 and returns to 0 when it reaches the ring length. It is always a multiple of 16 and stays below a non-zero length.
- R4: The ring is full when the offset after the next advance would equal the read offset. While it is full, `cmp_ready` stays low and no memory write starts.
- R5: A doorbell write clears the low 4 bits of the value. If the result is at or above the ring length, one ring length is subtracted, and the outcome becomes the read offset.
- R6: The write offset does not change while a memory write is outstanding. `mem_req`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`.
- R7: `eob_pulse` is high for exactly one cycle per record: the cycle after the `mem_ack` edge, which is also the first cycle in which the new write offset is visible.
- R8: Records are written in the order their completions were accepted, at consecutive ring offsets.
- R9: Writing the ring length clears both the write offset and the read offset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cmp_valid | input | 1 | A completion is offered |
| cmp_ready | output | 1 | The completion is taken on this edge |
| cmp_code | input | 4 | Completion code |
| cmp_info | input | 4 | Error information |
| mem_req | output | 1 | Record write request |
| mem_addr | output | ADDR_W | Record byte address |
| mem_wdata | output | 128 | Formatted record |
| mem_ack | input | 1 | Memory accepted and committed the write |
| eob_pulse | output | 1 | One-cycle event per written record |

## Verification
The bench fills the ring until the next advance would meet the read offset. A design that compared the current offset instead of the next one would overwrite an unread record, and one that ignored fullness would start a write there. It drives the wrap from the last slot back to zero and doorbell values beyond the length; a missing wrap or reduction would emit an address past the ring or a read offset that never matches. It stretches the memory acknowledge to catch a design that publishes the offset early or lets the request drift. It also pushes several records back to back to expose reordering or a lost pulse.

// File: rtl/ering_pkg.sv
package ering_pkg;
   localparam int REC_BYTES = 16;
   localparam int REC_SHIFT = 4;
   localparam int REC_BITS  = REC_BYTES * 8;

   localparam logic [11:0] OFS_BASE_LO = 12'h008;
   localparam logic [11:0] OFS_BASE_HI = 12'h00C;
   localparam logic [11:0] OFS_LEN     = 12'h010;
   localparam logic [11:0] OFS_WPTR    = 12'h020;
   localparam logic [11:0] OFS_DBELL   = 12'h400;

   localparam logic [3:0] CODE_DONE = 4'd1;
   localparam logic [3:0] CODE_FAIL = 4'd4;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_WRITE = 1'b1
   } wr_state_e;

   typedef struct packed {
      logic [3:0] code;
      logic [3:0] info;
   } cmp_rec_t;
endpackage

// File: rtl/ering_regs.sv
module ering_regs
   import ering_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 20,
   parameter int REG_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [LEN_W-1:0]  wr_ptr,
   output logic [31:0]       reg_rdata,
   output logic [ADDR_W-1:0] ring_base,
   output logic [LEN_W-1:0]  ring_len,
   output logic [LEN_W-1:0]  rd_off,
   output logic              len_load
);
   localparam int HI_W = ADDR_W - 32;

   logic [31:0]      base_lo_q;
   logic [HI_W-1:0]  base_hi_q;
   logic [31:0]      db_al;
   logic [31:0]      len_ext;
   logic [31:0]      db_red;

   generate
      if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_aw
         $error("ering_regs: ADDR_W must lie in 33..64");
      end
      if (LEN_W < REC_SHIFT + 1 || LEN_W > 31) begin : g_bad_lw
         $error("ering_regs: LEN_W must lie in 5..31");
      end
      if (REG_AW < 11) begin : g_bad_raw
         $error("ering_regs: REG_AW must reach the doorbell offset");
      end
   endgenerate

   wire hit_lo  = reg_addr == REG_AW'(OFS_BASE_LO);
   wire hit_hi  = reg_addr == REG_AW'(OFS_BASE_HI);
   wire hit_len = reg_addr == REG_AW'(OFS_LEN);
   wire hit_wp  = reg_addr == REG_AW'(OFS_WPTR);
   wire hit_db  = reg_addr == REG_AW'(OFS_DBELL);

   assign len_load = reg_wr_en && hit_len;

   // doorbell: align down to a record, then fold one ring length back in
   assign db_al   = {reg_wdata[31:REC_SHIFT], {REC_SHIFT{1'b0}}};
   assign len_ext = {{(32-LEN_W){1'b0}}, ring_len};
   assign db_red  = (db_al >= len_ext) ? (db_al - len_ext) : db_al;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
         ring_len  <= '0;
         rd_off    <= '0;
      end else if (reg_wr_en) begin
         if (hit_lo) base_lo_q <= reg_wdata;
         if (hit_hi) base_hi_q <= reg_wdata[HI_W-1:0];
         if (hit_len) begin
            ring_len <= {reg_wdata[LEN_W-1:REC_SHIFT], {REC_SHIFT{1'b0}}};
            rd_off   <= '0;
         end
         if (hit_db) rd_off <= db_red[LEN_W-1:0];
      end
   end

   assign ring_base = {base_hi_q, base_lo_q};

   always_comb begin
      reg_rdata = '0;
      if (hit_lo)  reg_rdata = base_lo_q;
      if (hit_hi)  reg_rdata = {{(64-ADDR_W){1'b0}}, base_hi_q};
      if (hit_len) reg_rdata = {{(32-LEN_W){1'b0}}, ring_len};
      if (hit_wp)  reg_rdata = {{(32-LEN_W){1'b0}}, wr_ptr};
   end

   a_r5_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      rd_off[REC_SHIFT-1:0] == '0);
   a_r9_len_clears_rd: assert property (@(posedge clk) disable iff (!rst_n)
      len_load |=> rd_off == '0);
endmodule

// File: rtl/ering_ptr.sv
module ering_ptr
   import ering_pkg::*;
#(
   parameter int LEN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] ring_len,
   input  logic [LEN_W-1:0] rd_off,
   input  logic             clear,
   input  logic             advance,
   output logic [LEN_W-1:0] wr_ptr,
   output logic             full
);
   localparam logic [LEN_W:0] STEP = (LEN_W+1)'(REC_BYTES);

   logic [LEN_W:0]   sum;
   logic [LEN_W-1:0] nxt;

   assign sum  = {1'b0, wr_ptr} + STEP;
   assign nxt  = (sum >= {1'b0, ring_len}) ? '0 : sum[LEN_W-1:0];
   assign full = (nxt == rd_off);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wr_ptr <= '0;
      else if (clear)   wr_ptr <= '0;
      else if (advance) wr_ptr <= nxt;
   end

   a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr[REC_SHIFT-1:0] == '0);
   a_r3_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_len != '0 && $stable(ring_len)) |-> wr_ptr < ring_len);
   a_r6_moves_on_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clear) && !$past(advance)) |-> $stable(wr_ptr));
endmodule

// File: rtl/ering_fmt.sv
module ering_fmt
   import ering_pkg::*;
#(
   parameter int DATA_W = 128
) (
   input  cmp_rec_t          rec,
   output logic [DATA_W-1:0] wdata
);
   localparam int WORDS = DATA_W / 32;

   generate
      if (DATA_W != REC_BITS) begin : g_bad_dw
         $error("ering_fmt: DATA_W must equal one record");
      end
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         if (w == 0) begin : g_head
            assign wdata[31:0] = {rec.code, rec.info, 24'h0};
         end else begin : g_pad
            assign wdata[w*32 +: 32] = 32'h0;
         end
      end
   endgenerate
endmodule

// File: rtl/ering_writer.sv
module ering_writer
   import ering_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 20,
   parameter int REG_AW = 12,
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cmp_valid,
   output logic              cmp_ready,
   input  logic [3:0]        cmp_code,
   input  logic [3:0]        cmp_info,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   output logic              eob_pulse
);
   logic [ADDR_W-1:0] ring_base;
   logic [LEN_W-1:0]  ring_len;
   logic [LEN_W-1:0]  rd_off;
   logic [LEN_W-1:0]  wr_ptr;
   logic              len_load;
   logic              full;
   logic              take;
   logic              done;
   wr_state_e         state_q;
   cmp_rec_t          rec_q;

   ering_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .wr_ptr(wr_ptr), .reg_rdata(reg_rdata),
      .ring_base(ring_base), .ring_len(ring_len), .rd_off(rd_off),
      .len_load(len_load)
   );

   ering_ptr #(.LEN_W(LEN_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ring_len(ring_len), .rd_off(rd_off),
      .clear(len_load), .advance(done), .wr_ptr(wr_ptr), .full(full)
   );

   ering_fmt #(.DATA_W(DATA_W)) u_fmt (.rec(rec_q), .wdata(mem_wdata));

   assign cmp_ready = (state_q == ST_IDLE) && (ring_len != '0) && !full;
   assign take      = cmp_valid && cmp_ready;
   assign done      = (state_q == ST_WRITE) && mem_ack;
   assign mem_req   = (state_q == ST_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rec_q     <= '0;
         mem_addr  <= '0;
         eob_pulse <= 1'b0;
      end else begin
         eob_pulse <= done;
         if (take) begin
            state_q  <= ST_WRITE;
            rec_q    <= '{code: cmp_code, info: cmp_info};
            mem_addr <= ring_base + {{(ADDR_W-LEN_W){1'b0}}, wr_ptr};
         end else if (done) begin
            state_q  <= ST_IDLE;
         end
      end
   end

   a_r4_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !cmp_ready);
   a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
   a_r7_pulse_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eob_pulse) |-> $past(mem_req && mem_ack));
   a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      eob_pulse |=> !eob_pulse);
   a_r2_word0_only: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_wdata[23:0] == '0));
endmodule

// File: tb/ering_writer_tb.sv
module ering_writer_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE_LO = 32'h0000_2000;
   localparam logic [31:0] BASE_HI = 32'h0000_0001;
   localparam logic [63:0] BASE    = {BASE_HI, BASE_LO};

   logic         clk = 0;
   logic         rst_n = 0;
   logic         reg_wr_en = 0;
   logic [11:0]  reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         cmp_valid = 0;
   logic         cmp_ready;
   logic [3:0]   cmp_code = '0;
   logic [3:0]   cmp_info = '0;
   logic         mem_req;
   logic [63:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic         mem_ack = 0;
   logic         eob_pulse;

   int checks = 0;
   int errors = 0;
   int ack_lat = 0;
   int wait_cnt = 0;
   int log_n = 0;
   int eob_n = 0;
   logic [63:0]  log_addr [16];
   logic [127:0] log_data [16];

   ering_writer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_valid(cmp_valid),
      .cmp_ready(cmp_ready), .cmp_code(cmp_code), .cmp_info(cmp_info),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .eob_pulse(eob_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (eob_pulse) eob_n++;

   // memory responder: acknowledges after ack_lat waiting cycles
   initial forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req && rst_n) begin
         if (wait_cnt >= ack_lat) begin
            mem_ack = 1;
            if (log_n < 16) begin
               log_addr[log_n] = mem_addr;
               log_data[log_n] = mem_wdata;
            end
            log_n++;
            wait_cnt = 0;
         end else wait_cnt++;
      end
   end

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 0;
   endtask

   task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic push(input logic [3:0] c, input logic [3:0] i);
      @(negedge clk);
      cmp_valid = 1; cmp_code = c; cmp_info = i;
      while (!cmp_ready) @(negedge clk);
      @(negedge clk);
      cmp_valid = 0;
   endtask

   task automatic wait_records(input int n);
      while (log_n < n || eob_n < n) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [127:0] rec(input logic [3:0] c, input logic [3:0] i);
      return {96'h0, c, i, 24'h0};
   endfunction

   task automatic t_reset;
      logic [31:0] v;
      check("R1 cmp_ready after reset", cmp_ready, 0);
      check("R1 mem_req after reset", mem_req, 0);
      check("R7 eob after reset", eob_pulse, 0);
      rd_reg(12'h020, v); check("R1 write offset after reset", v, 0);
      rd_reg(12'h010, v); check("R1 length after reset", v, 0);
      rd_reg(12'h008, v); check("R1 base low after reset", v, 0);
   endtask

   task automatic t_config;
      logic [31:0] v;
      wr_reg(12'h008, BASE_LO);
      wr_reg(12'h00C, BASE_HI);
      wr_reg(12'h010, 32'd64);
      @(negedge clk);
      rd_reg(12'h008, v); check("R1 base low", v, BASE_LO);
      rd_reg(12'h00C, v); check("R1 base high", v, BASE_HI);
      rd_reg(12'h010, v); check("R1 length", v, 64);
      rd_reg(12'h400, v); check("R1 doorbell reads zero", v, 0);
      check("R1 ready once configured", cmp_ready, 1);
   endtask

   task automatic t_single;
      logic [31:0] v;
      push(4'd1, 4'h3);
      wait_records(1);
      check("R2 first address", log_addr[0], BASE);
      check("R2 success record", log_data[0], rec(4'd1, 4'h3));
      rd_reg(12'h020, v); check("R3 offset after one record", v, 16);
   endtask

   task automatic t_slow_ack;
      logic [31:0] v;
      ack_lat = 5;
      push(4'd1, 4'h7);
      repeat (3) begin
         @(negedge clk);
         check("R6 request held during wait", mem_req, 1);
         rd_reg(12'h020, v); check("R6 offset frozen before ack", v, 16);
         check("R7 no pulse before ack", eob_pulse, 0);
      end
      // the pulse and the new offset appear together
      while (!eob_pulse) @(negedge clk);
      rd_reg(12'h020, v); check("R7 offset visible with pulse", v, 32);
      @(negedge clk);
      check("R7 pulse lasts one cycle", eob_pulse, 0);
      check("R2 address second record", log_addr[1], BASE + 64'd16);
      ack_lat = 0;
   endtask

   task automatic t_full_wrap;
      logic [31:0] v;
      push(4'd1, 4'h1);
      wait_records(3);
      rd_reg(12'h020, v); check("R3 offset at last slot", v, 48);
      check("R4 ready low when full", cmp_ready, 0);
      @(negedge clk);
      cmp_valid = 1; cmp_code = 4'd1; cmp_info = 4'h5;
      repeat (4) begin
         @(negedge clk);
         check("R4 no write while full", mem_req, 0);
      end
      wr_reg(12'h400, 32'd32);
      while (!cmp_ready) @(negedge clk);
      @(negedge clk);
      cmp_valid = 0;
      wait_records(4);
      check("R3 last slot address", log_addr[3], BASE + 64'd48);
      rd_reg(12'h020, v); check("R3 wrap to zero", v, 0);
   endtask

   task automatic t_doorbell_fold;
      // 80 folds to 16; with offset 0 the next slot 16 collides
      wr_reg(12'h400, 32'd80);
      @(negedge clk);
      check("R5 folded doorbell makes ring full", cmp_ready, 0);
      wr_reg(12'h400, 32'd37);
      @(negedge clk);
      check("R5 doorbell 37 aligns to 32", cmp_ready, 1);
      wr_reg(12'h400, 32'd31);
      @(negedge clk);
      check("R5 doorbell 31 aligns to 16", cmp_ready, 0);
      wr_reg(12'h400, 32'd0);
      @(negedge clk);
      check("R5 doorbell zero frees ring", cmp_ready, 1);
   endtask

   task automatic t_error;
      logic [31:0] v;
      push(4'd4, 4'hF);
      wait_records(5);
      check("R2 error record address", log_addr[4], BASE);
      check("R2 error record", log_data[4], rec(4'd4, 4'hF));
      rd_reg(12'h020, v); check("R3 offset after error record", v, 16);
   endtask

   task automatic t_order;
      wr_reg(12'h400, 32'd16);
      push(4'd1, 4'h1);
      push(4'd4, 4'h2);
      push(4'd1, 4'h3);
      wait_records(8);
      check("R8 order addr 0", log_addr[5], BASE + 64'd16);
      check("R8 order addr 1", log_addr[6], BASE + 64'd32);
      check("R8 order addr 2", log_addr[7], BASE + 64'd48);
      check("R8 order data 0", log_data[5], rec(4'd1, 4'h1));
      check("R8 order data 1", log_data[6], rec(4'd4, 4'h2));
      check("R8 order data 2", log_data[7], rec(4'd1, 4'h3));
      check("R4 full after wrap", cmp_ready, 0);
      check("R7 one pulse per record", eob_n, log_n);
   endtask

   task automatic t_len_reload;
      logic [31:0] v;
      wr_reg(12'h010, 32'd64);
      @(negedge clk);
      rd_reg(12'h020, v); check("R9 length write clears offset", v, 0);
      check("R9 read offset cleared so ring not full", cmp_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_config;
      t_single;
      t_slow_ack;
      t_full_wrap;
      t_doorbell_fold;
      t_error;
      t_order;
      t_len_reload;
      repeat (3) @(negedge clk);
      check("R7 pulse count matches writes", eob_n, log_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule